// File: doc/BRIEF.md
# Modulo and Bit-Reversed Address Generator

This unit produces the data-memory address for one operand stream of a signal-processing datapath. A configuration load fixes a base address, a buffer length K, a step and an addressing mode. Each asserted advance strobe then moves an internal offset, and the unit presents the registered address base + offset.

Three modes share the one offset register. Linear mode is a plain post-increment. Modulo mode keeps the offset inside a circular window of K words, where K may be any length and need not be a power of two. A filter delay line can therefore overwrite its oldest sample in place and move only the pointer, without moving any stored data. Bit-reversed mode steps through the reordered index sequence that an FFT of 2^L points needs. It does this by adding N/2 with the carry running from the most significant offset bit towards bit 0.

Top module: `agu_addr_gen`

## Requirements
- R1: After reset, addr_out is 0 and the latched mode is linear with offset 0.
- R2: When cfg_load is high at a clock edge, the offset becomes 0 and base, K, step, mode and FFT size are latched, so addr_out equals cfg_base after that edge. A load takes priority over a simultaneous step_en.
- R3: In linear mode (cfg_mode code 0), each advance adds the step to the offset, modulo 2^AW.
- R4: With both step_en and cfg_load low, addr_out holds its value, whatever the cfg_* inputs do.
- R5: In modulo mode (code 1), each advance forms offset + step. When that sum is greater than or equal to K, K is subtracted from it. K may be any value from 1 to 2^OW, and step must not exceed K.
- R6: In modulo mode with step equal to K, or with K = 1, the address stays at the base on every advance.
- R7: In bit-reversed mode (code 2) with N = 2^cfg_fft_log2, each advance adds N/2 with the carry propagating towards bit 0, and drops the carry out of bit 0. For N = 8 the offsets are 0,4,2,6,1,5,3,7, then 0 again.
- R8: Mode code 3 holds the offset when step_en is high.
- R9: addr_out equals (base + offset) truncated to AW bits, so it wraps past the top of the address space.
- R10: addr_out changes at the first clock edge that samples step_en high, and does not change before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Latch the configuration and clear the offset |
| cfg_base | input | AW | Base address of the window |
| cfg_len | input | OW+1 | Circular length K, from 1 to 2^OW |
| cfg_step | input | AW | Offset increment (at most K in modulo mode) |
| cfg_mode | input | 2 | 0 linear, 1 modulo, 2 bit-reversed, 3 hold |
| cfg_fft_log2 | input | LW | log2 of the FFT size, from 0 to OW |
| step_en | input | 1 | Advance the offset at this edge |
| addr_out | output | AW | Registered current address |

## Verification
The hardest states to reach from the ports are the modulo wrap at the largest length K = 2^OW with a step that is not a divisor of K, and the bit-reversed wrap from all ones back to zero at the largest FFT size. Each needs a long run of advances after a single load. The stimulus loads these configurations directly and then strobes step_en for hundreds of consecutive cycles. A random phase then reloads the configuration at arbitrary points and changes the strobe density, which exercises loads that land mid-sequence and loads that collide with an advance. A behavioural model computes the reverse-carry step by reversing the index, incrementing it and reversing it back, and checks every cycle against that model.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    AGU_LIN  = 2'd0,
    AGU_MOD  = 2'd1,
    AGU_REV  = 2'd2,
    AGU_HOLD = 2'd3
  } agu_mode_e;
endpackage

// File: rtl/agu_mod_step.sv
module agu_mod_step #(
  parameter int OW = 8
) (
  input  logic [OW-1:0] off_i,
  input  logic [OW:0]   step_i,
  input  logic [OW:0]   len_i,
  output logic [OW-1:0] nxt_o,
  output logic          wrap_o
);
  // offset + step, folded back into [0, K) by one compare and subtract
  function automatic logic [OW+1:0] raw_sum(logic [OW-1:0] o, logic [OW:0] s);
    return {2'b00, o} + {1'b0, s};
  endfunction

  function automatic logic [OW-1:0] fold(logic [OW+1:0] sum, logic [OW:0] k);
    logic [OW+1:0] r;
    r = (sum >= {1'b0, k}) ? (sum - {1'b0, k}) : sum;
    return r[OW-1:0];
  endfunction

  logic [OW+1:0] sum;
  always_comb begin
    sum    = raw_sum(off_i, step_i);
    wrap_o = (sum >= {1'b0, len_i});
    nxt_o  = fold(sum, len_i);
  end
endmodule

// File: rtl/agu_rev_step.sv
module agu_rev_step #(
  parameter int OW = 8,
  parameter int LW = 4
) (
  input  logic [OW-1:0] off_i,
  input  logic [LW-1:0] lg_i,
  output logic [OW-1:0] nxt_o,
  output logic          wrap_o
);
  // active-bit mask: bit g is in range when g < log2(N)
  logic [OW-1:0] act;
  for (genvar g = 0; g < OW; g++) begin : g_mask
    assign act[g] = (int'(lg_i) > g);
  end

  // add N/2: start at the top active bit, carry moves down towards bit 0
  function automatic logic [OW-1:0] rc_inc(logic [OW-1:0] v, logic [OW-1:0] m);
    logic [OW-1:0] r;
    logic          c;
    r = v & m;
    c = 1'b1;
    for (int i = OW-1; i >= 0; i--) begin
      if (m[i] && c) begin
        c    = r[i];
        r[i] = ~r[i];
      end
    end
    return r;
  endfunction

  always_comb begin
    nxt_o  = rc_inc(off_i, act);
    wrap_o = (nxt_o == '0);
  end
endmodule

// File: rtl/agu_addr_gen.sv
module agu_addr_gen #(
  parameter int AW = 16,
  parameter int OW = 8,
  localparam int KW = OW + 1,
  localparam int LW = $clog2(OW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [AW-1:0] cfg_base,
  input  logic [KW-1:0] cfg_len,
  input  logic [AW-1:0] cfg_step,
  input  logic [1:0]    cfg_mode,
  input  logic [LW-1:0] cfg_fft_log2,
  input  logic          step_en,
  output logic [AW-1:0] addr_out
);
  import agu_pkg::*;

  logic [AW-1:0] base_q, step_q, off_q, addr_q;
  logic [KW-1:0] len_q;
  logic [LW-1:0] lg_q;
  agu_mode_e     mode_q;

  // named events for the checker
  logic          adv_fire;
  logic          mod_wrap, rev_wrap;
  logic [OW-1:0] mod_nxt, rev_nxt;
  logic [AW-1:0] off_adv, off_d, base_d;

  assign adv_fire = step_en & ~cfg_load;

  agu_mod_step #(.OW(OW)) i_mod (
    .off_i  (off_q[OW-1:0]),
    .step_i (step_q[KW-1:0]),
    .len_i  (len_q),
    .nxt_o  (mod_nxt),
    .wrap_o (mod_wrap)
  );

  agu_rev_step #(.OW(OW), .LW(LW)) i_rev (
    .off_i  (off_q[OW-1:0]),
    .lg_i   (lg_q),
    .nxt_o  (rev_nxt),
    .wrap_o (rev_wrap)
  );

  always_comb begin
    unique case (mode_q)
      AGU_LIN: off_adv = off_q + step_q;
      AGU_MOD: off_adv = AW'(mod_nxt);
      AGU_REV: off_adv = AW'(rev_nxt);
      default: off_adv = off_q;
    endcase
  end

  always_comb begin
    base_d = cfg_load ? cfg_base : base_q;
    if (cfg_load)      off_d = '0;
    else if (step_en)  off_d = off_adv;
    else               off_d = off_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      step_q <= '0;
      len_q  <= KW'(1);
      lg_q   <= '0;
      mode_q <= AGU_LIN;
      off_q  <= '0;
      addr_q <= '0;
    end else begin
      if (cfg_load) begin
        step_q <= cfg_step;
        len_q  <= cfg_len;
        lg_q   <= cfg_fft_log2;
        mode_q <= agu_mode_e'(cfg_mode);
      end
      base_q <= base_d;
      off_q  <= off_d;
      addr_q <= base_d + off_d;
    end
  end

  assign addr_out = addr_q;
endmodule

// File: rtl/agu_addr_gen_chk.sv
module agu_addr_gen_chk #(
  parameter int AW = 16,
  parameter int OW = 8,
  parameter int KW = 9,
  parameter int LW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_load,
  input logic [AW-1:0] cfg_base,
  input logic          step_en,
  input logic          adv_fire,
  input logic          mod_wrap,
  input logic          rev_wrap,
  input logic [1:0]    mode_q,
  input logic [AW-1:0] off_q,
  input logic [AW-1:0] base_q,
  input logic [KW-1:0] len_q,
  input logic [LW-1:0] lg_q,
  input logic [AW-1:0] addr_out
);
  logic [AW:0] off_x, len_x;
  assign off_x = {1'b0, off_q};
  assign len_x = (AW+1)'(len_q);

  AST_LOAD_TO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> addr_out == $past(cfg_base)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_load && !step_en) |=> $stable(addr_out)); // R4
  AST_MOD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd1) |-> off_x < len_x); // R5
  AST_MOD_WRAP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_fire && mode_q == 2'd1 && mod_wrap) |=> off_q <= $past(off_q)); // R5
  AST_REV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd2) |-> (off_q >> lg_q) == '0); // R7
  AST_REV_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_fire && mode_q == 2'd2 && rev_wrap) |=> off_q == '0); // R7
  AST_HOLD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_fire && mode_q == 2'd3) |=> $stable(addr_out)); // R8
  AST_ADDR_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    addr_out == AW'(base_q + off_q)); // R9
endmodule

bind agu_addr_gen agu_addr_gen_chk #(.AW(AW), .OW(OW), .KW(KW), .LW(LW)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_load (cfg_load),
  .cfg_base (cfg_base),
  .step_en  (step_en),
  .adv_fire (adv_fire),
  .mod_wrap (mod_wrap),
  .rev_wrap (rev_wrap),
  .mode_q   (mode_q),
  .off_q    (off_q),
  .base_q   (base_q),
  .len_q    (len_q),
  .lg_q     (lg_q),
  .addr_out (addr_out)
);

// File: tb/test_agu_addr_gen.sv
module test_agu_addr_gen;
  localparam int AW = 16;
  localparam int OW = 8;
  localparam int KW = OW + 1;
  localparam int LW = $clog2(OW + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_load = 1'b0;
  logic [AW-1:0] cfg_base = '0;
  logic [KW-1:0] cfg_len = KW'(1);
  logic [AW-1:0] cfg_step = '0;
  logic [1:0]    cfg_mode = '0;
  logic [LW-1:0] cfg_fft_log2 = '0;
  logic          step_en = 1'b0;
  logic [AW-1:0] addr_out;

  always #5 clk = ~clk;

  agu_addr_gen #(.AW(AW), .OW(OW)) i_agu_addr_gen (
    .clk, .rst_n, .cfg_load, .cfg_base, .cfg_len, .cfg_step,
    .cfg_mode, .cfg_fft_log2, .step_en, .addr_out
  );

  int n_cmp = 0;
  int n_bad = 0;

  // reference model state
  int m_base = 0, m_len = 1, m_step = 0, m_mode = 0, m_lg = 0, m_off = 0;

  function automatic int bitrev(int v, int bits);
    int r = 0;
    for (int i = 0; i < bits; i++) r = (r << 1) | ((v >> i) & 1);
    return r;
  endfunction

  function automatic int exp_addr();
    return (m_base + m_off) % (1 << AW);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_base = 0; m_len = 1; m_step = 0; m_mode = 0; m_lg = 0; m_off = 0;
    end else if (cfg_load) begin
      m_base = int'(cfg_base); m_len = int'(cfg_len); m_step = int'(cfg_step);
      m_mode = int'(cfg_mode); m_lg = int'(cfg_fft_log2); m_off = 0;
    end else if (step_en) begin
      case (m_mode)
        0: m_off = (m_off + m_step) % (1 << AW);
        1: begin
          m_off = m_off + m_step;
          if (m_off >= m_len) m_off = m_off - m_len;
        end
        2: m_off = bitrev((bitrev(m_off, m_lg) + 1) % (1 << m_lg), m_lg);
        default: ;
      endcase
    end
  end

  task automatic check(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: addr_out=%0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // every-cycle comparison against the model, away from the clock edge
  always @(negedge clk) begin
    if (rst_n) begin
      case (m_mode)
        0: check("R3 linear per-cycle", int'(addr_out), exp_addr());
        1: check("R5 modulo per-cycle", int'(addr_out), exp_addr());
        2: check("R7 bitrev per-cycle", int'(addr_out), exp_addr());
        default: check("R8 hold per-cycle", int'(addr_out), exp_addr());
      endcase
    end
  end

  // one clock of stimulus; returns 2 ns after the edge with strobes low
  task automatic cyc(bit ld, int base, int len, int stp, int mode, int lg, bit adv);
    cfg_load = ld; cfg_base = AW'(base); cfg_len = KW'(len); cfg_step = AW'(stp);
    cfg_mode = 2'(mode); cfg_fft_log2 = LW'(lg); step_en = adv;
    @(posedge clk); #2;
    cfg_load = 1'b0; step_en = 1'b0;
  endtask

  task automatic load(int base, int len, int stp, int mode, int lg);
    cyc(1'b1, base, len, stp, mode, lg, 1'b0);
  endtask

  task automatic adv(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 0, 1, 0, 0, 0, 1'b1);
  endtask

  initial begin
    #1_500_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  int rev8 [9] = '{0, 4, 2, 6, 1, 5, 3, 7, 0};

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk); #2;
    check("R1 reset address", int'(addr_out), 0);

    // R3 linear stepping
    load('h100, 1, 3, 0, 0);
    check("R2 load shows base", int'(addr_out), 'h100);
    adv(5);
    check("R3 linear after 5 steps", int'(addr_out), 'h100 + 15);

    // R10 timing: no change before the edge, change after it
    cfg_step = AW'(3); step_en = 1'b1;
    #2 check("R10 before edge", int'(addr_out), 'h100 + 15);
    @(posedge clk); #2; step_en = 1'b0;
    check("R10 after edge", int'(addr_out), 'h100 + 18);

    // R4 cfg inputs wiggle without load or step
    cfg_base = AW'('h777); cfg_mode = 2'd2; cfg_step = AW'(9); cfg_len = KW'(4);
    repeat (4) @(posedge clk); #2;
    check("R4 idle holds", int'(addr_out), 'h100 + 18);

    // R5 modulo K=5 step 2
    load('h40, 5, 2, 1, 0);
    adv(3);
    check("R5 K5 wrap offset 1", int'(addr_out), 'h40 + 1);
    adv(2);
    check("R5 K5 back to base", int'(addr_out), 'h40);
    load('h80, 7, 3, 1, 0);
    adv(40);
    load('h1000, 256, 200, 1, 0);
    adv(2);
    check("R5 K256 step200", int'(addr_out), 'h1000 + 144);
    adv(300);
    // R6 step equal to K, and K of one
    load('h50, 7, 7, 1, 0);
    adv(4);
    check("R6 step==K stays", int'(addr_out), 'h50);
    load('h60, 1, 1, 1, 0);
    adv(3);
    check("R6 K=1 stays", int'(addr_out), 'h60);

    // R7 bit-reversed N=8
    load('h200, 1, 0, 2, 3);
    for (int i = 1; i < 9; i++) begin
      adv(1);
      check("R7 N8 sequence", int'(addr_out), 'h200 + rev8[i]);
    end
    load('h400, 1, 0, 2, OW);
    adv(600);
    load('h500, 1, 0, 2, 0);
    adv(3);
    check("R7 N1 stays", int'(addr_out), 'h500);

    // R8 hold code
    load('h321, 9, 4, 3, 2);
    adv(5);
    check("R8 hold code", int'(addr_out), 'h321);

    // R9 address wrap past top
    load('hFFFE, 1, 5, 0, 0);
    adv(1);
    check("R9 linear wrap", int'(addr_out), 'h0003);
    load('hFFF0, 100, 30, 1, 0);
    adv(20);

    // R2 load beats a simultaneous advance
    adv(2);
    cyc(1'b1, 'h300, 10, 4, 1, 0, 1'b1);
    check("R2 load over advance", int'(addr_out), 'h300);

    // random configurations and strobe density
    for (int i = 0; i < 4000; i++) begin
      bit ld = ($urandom % 25) == 0;
      int md = $urandom % 4;
      int k  = 1 + ($urandom % 256);
      int st = (md == 1) ? ($urandom % (k + 1)) : ($urandom % 65536);
      cyc(ld, $urandom % 65536, k, st, md, $urandom % (OW + 1), ($urandom % 10) < 7);
    end

    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule